// File: doc/BRIEF.md
# Multi-Protocol Host Bus Front End

This block is the host-facing entry point of a graphic display controller. A host reaches it in one of three ways, chosen by two static mode pins. The first is an 8-bit parallel bus with separate active-low read and write strobes. The second is an 8-bit parallel bus with one active-high enable and a read/write direction line. The third is a write-only serial stream that borrows two of the data pins, one for data and one for the clock.

Every pin is synchronised into the faster system clock. The block then works out when an access completes and which kind of byte it carries, using the register-select line: a command byte or a display-data byte. Each completed write leaves the block as a one-cycle strobe, together with the byte and its type.

For parallel reads, the block puts the supplied return data on its output bus and raises a tristate enable. The pad ring uses that enable to drive the shared data pins. Two chip-select pins, one active-low and one active-high, must both be asserted before anything is accepted or driven.

Top module: `host_bus_front`

## Requirements
- R1: The block is selected only when `selLowN` is 0 and `selHigh` is 1. While it is not selected, no write strobe is produced and `dataOe` stays 0, whatever the strobe and data pins do.
- R2: `regSel` = 1 marks a written byte as display data (`wrIsData` = 1). `regSel` = 0 marks it as a command (`wrIsData` = 0).
- R3: In strobe-pair mode (`busStyle` = 0, `parallelMode` = 1), one write is issued for each rising edge of `wrOrDir` while the block is selected. It carries the byte present on `busIn[7:0]` at that edge.
- R4: In strobe-pair mode, `dataOe` is 1 and `dataOut` equals `rdData` while `rdOrEnable` is 0 and the block is selected. Otherwise `dataOe` is 0.
- R5: In enable/direction mode (`busStyle` = 1, `parallelMode` = 1), one write is issued for each falling edge of `rdOrEnable` that occurs while `wrOrDir` is 0. It carries the byte present on `busIn` at that edge.
- R6: In enable/direction mode, `dataOe` is 1 and `dataOut` equals `rdData` while both `rdOrEnable` and `wrOrDir` are 1 and the block is selected.
- R7: In serial mode (`parallelMode` = 0), `busIn[7]` is the data bit and `busIn[6]` is the clock. Bits are shifted MSB first on rising clock edges. After the eighth bit, one write is issued with the assembled byte, typed by the `regSel` level at that eighth bit.
- R8: Serial mode is write-only. `dataOe` stays 0, and edges on `rdOrEnable` and `wrOrDir` produce no write.
- R9: Deselecting the block in the middle of a serial byte discards the partial byte. The next byte is assembled starting from its first bit.
- R10: An active-low `rstN` clears the serial bit count and any pending strobe. `wrStrobe` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any host signal |
| rstN | input | 1 | Asynchronous active-low reset |
| selLowN | input | 1 | Active-low chip select |
| selHigh | input | 1 | Active-high chip select |
| regSel | input | 1 | 1 = display data, 0 = command |
| busStyle | input | 1 | 0 = separate read/write strobes, 1 = enable plus direction |
| parallelMode | input | 1 | 1 = parallel bus, 0 = serial stream |
| rdOrEnable | input | 1 | Read strobe (active low) or enable (active high) |
| wrOrDir | input | 1 | Write strobe (active low) or direction (1 = read) |
| busIn | input | 8 | Data pins as seen from the pads; bits 7/6 are serial data/clock |
| rdData | input | 8 | Return data for host reads |
| dataOut | output | 8 | Data to drive onto the pins |
| dataOe | output | 1 | Tristate enable for the data pins |
| wrStrobe | output | 1 | One-cycle pulse per accepted write |
| wrByte | output | 8 | Written byte, valid with `wrStrobe` |
| wrIsData | output | 1 | Type of the written byte, valid with `wrStrobe` |

## Verification
The hardest case to reach is a serial byte cut short. This happens either because the chip select drops or because reset hits after a few bits. The stale bit count and shift contents then stay invisible until the next full byte is sent. To expose them, the stimulus clocks in three bits, deselects or resets, and then sends a complete byte whose value differs from any possible concatenation with the leftover bits. A byte that comes out exactly as sent proves the partial state was discarded. Read-enable behaviour in serial and deselected states is probed by holding the read pins in their active levels and sampling `dataOe` after the synchroniser has settled.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;

  // Per-cycle events the control hands to the datapath
  typedef struct packed {
    logic capParallel;   // latch parallel byte as a write
    logic shiftBit;      // shift one serial bit in
    logic commitSerial;  // the shifted bit completes a byte
    logic driveBus;      // host read in progress
  } ctrlEvents_t;

endpackage

// File: rtl/host_bus_sync.sv
module host_bus_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] pinsOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= pinsIn;
        else stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pinsOut = stage[STAGES-1];

endmodule

// File: rtl/host_bus_ctrl.sv
module host_bus_ctrl
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selLowNS,
  input  logic        selHighS,
  input  logic        busStyleS,
  input  logic        parallelModeS,
  input  logic        rdOrEnableS,
  input  logic        wrOrDirS,
  input  logic        serClkS,
  output ctrlEvents_t ctl
);

  logic             selected, serialMode;
  logic             wrPrev, rdPrev, sclkPrev;
  logic             wrRise, enFall, sclkRise;
  logic [CNT_W-1:0] bitCnt;

  assign selected   = !selLowNS && selHighS;
  assign serialMode = !parallelModeS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b1;
      rdPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      wrPrev   <= wrOrDirS;
      rdPrev   <= rdOrEnableS;
      sclkPrev <= serClkS;
    end
  end

  assign wrRise   = wrOrDirS && !wrPrev;
  assign enFall   = !rdOrEnableS && rdPrev;
  assign sclkRise = serClkS && !sclkPrev;

  always_comb begin
    ctl = '0;
    if (selected && !serialMode) begin
      ctl.capParallel = busStyleS ? (enFall && !wrOrDirS) : wrRise;
      ctl.driveBus    = busStyleS ? (rdOrEnableS && wrOrDirS) : !rdOrEnableS;
    end
    if (selected && serialMode) begin
      ctl.shiftBit     = sclkRise;
      ctl.commitSerial = sclkRise && (bitCnt == CNT_W'(DATA_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!selected || !serialMode) bitCnt <= '0;
    else if (ctl.shiftBit) bitCnt <= bitCnt + 1'b1;
  end

  // R9: a deselect leaves no partial byte behind
  p_deselect_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> (bitCnt == '0));

  // R8: no read drive while a serial byte is being assembled
  p_serial_no_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != '0) |-> !ctl.driveBus);

  // R7: a serial commit happens only as the last bit arrives
  p_commit_last_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitSerial |-> (bitCnt == CNT_W'(DATA_W - 1)));

  // R1: no events without selection one cycle earlier having been evaluated
  p_unselected_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (selLowNS || !selHighS) |-> (ctl == '0));

endmodule

// File: rtl/host_bus_datapath.sv
module host_bus_datapath
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlEvents_t       ctl,
  input  logic [DATA_W-1:0] busS,
  input  logic              serBitS,
  input  logic              regSelS,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrByte,
  output logic              wrIsData
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftBit) shiftReg <= {shiftReg[DATA_W-2:0], serBitS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrByte   <= '0;
      wrIsData <= 1'b0;
    end else begin
      wrStrobe <= ctl.capParallel || ctl.commitSerial;
      if (ctl.capParallel) begin
        wrByte   <= busS;
        wrIsData <= regSelS;
      end else if (ctl.commitSerial) begin
        wrByte   <= {shiftReg[DATA_W-2:0], serBitS};
        wrIsData <= regSelS;
      end
    end
  end

  assign dataOe  = ctl.driveBus;
  assign dataOut = ctl.driveBus ? rdData : '0;

  // R10: every strobe is a single-cycle pulse
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R3: a strobe always follows a write event from the control
  p_strobe_has_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStrobe) |-> $past(ctl.capParallel || ctl.commitSerial));

  // R4: nothing leaks onto the bus while it is not driven
  p_idle_bus_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

endmodule

// File: rtl/host_bus_front.sv
module host_bus_front
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              regSel,
  input  logic              busStyle,
  input  logic              parallelMode,
  input  logic              rdOrEnable,
  input  logic              wrOrDir,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrByte,
  output logic              wrIsData
);

  localparam int CTRL_PINS = 7;
  localparam int SYNC_W    = CTRL_PINS + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST =
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

  logic [SYNC_W-1:0] syncIn, syncOut;
  logic              selLowNS, selHighS, regSelS, busStyleS, parallelModeS;
  logic              rdOrEnableS, wrOrDirS;
  logic [DATA_W-1:0] busS;
  ctrlEvents_t       ctl;

  assign syncIn = {selLowN, selHigh, regSel, busStyle, parallelMode,
                   rdOrEnable, wrOrDir, busIn};

  host_bus_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .pinsIn(syncIn), .pinsOut(syncOut));

  assign {selLowNS, selHighS, regSelS, busStyleS, parallelModeS,
          rdOrEnableS, wrOrDirS, busS} = syncOut;

  host_bus_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .selLowNS(selLowNS), .selHighS(selHighS), .busStyleS(busStyleS),
    .parallelModeS(parallelModeS), .rdOrEnableS(rdOrEnableS),
    .wrOrDirS(wrOrDirS), .serClkS(busS[DATA_W-2]), .ctl(ctl));

  host_bus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busS(busS),
    .serBitS(busS[DATA_W-1]), .regSelS(regSelS), .rdData(rdData),
    .dataOut(dataOut), .dataOe(dataOe), .wrStrobe(wrStrobe),
    .wrByte(wrByte), .wrIsData(wrIsData));

endmodule

// File: tb/tb_host_bus_front.sv
module tb_host_bus_front;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rstN = 0;
  logic       selLowN = 1, selHigh = 0, regSel = 0, busStyle = 0;
  logic       parallelMode = 1, rdOrEnable = 1, wrOrDir = 1;
  logic [7:0] busIn = 0, rdData = 0;
  logic [7:0] dataOut, wrByte;
  logic       dataOe, wrStrobe, wrIsData;

  int checks = 0, errors = 0, strobeCount = 0;
  logic [7:0] lastByte = 0;
  logic       lastIsData = 0;
  bit         done = 0;

  host_bus_front dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (wrStrobe) begin
    strobeCount++;
    lastByte   = wrByte;
    lastIsData = wrIsData;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic selectChip(logic on);
    selLowN = !on; selHigh = on;
  endtask

  task automatic pairWrite(logic [7:0] b, logic rs);
    busIn = b; regSel = rs; wrOrDir = 0; waitN(4);
    wrOrDir = 1; waitN(6);
  endtask

  task automatic enWrite(logic [7:0] b, logic rs);
    busIn = b; regSel = rs; wrOrDir = 0; rdOrEnable = 1; waitN(4);
    rdOrEnable = 0; waitN(6); wrOrDir = 1; waitN(2);
  endtask

  task automatic serialBits(logic [7:0] b, int nbits, logic rs);
    regSel = rs;
    for (int i = 7; i > 7 - nbits; i--) begin
      busIn[7] = b[i]; busIn[6] = 0; waitN(2);
      busIn[6] = 1; waitN(2);
    end
    busIn[6] = 0; waitN(6);
  endtask

  task automatic testReset();
    check("R10 strobe low after reset", wrStrobe, 0);
    check("R10 oe low after reset", dataOe, 0);
    check("R10 no strobes during reset", strobeCount, 0);
  endtask

  task automatic testPairWrites();
    int c;
    busStyle = 0; parallelMode = 1; selectChip(1); waitN(4);
    c = strobeCount;
    pairWrite(8'hA5, 0);
    check("R3 pair cmd count", strobeCount, c + 1);
    check("R3 pair cmd byte", lastByte, 8'hA5);
    check("R2 pair cmd type", lastIsData, 0);
    pairWrite(8'h3C, 1);
    check("R3 pair data count", strobeCount, c + 2);
    check("R3 pair data byte", lastByte, 8'h3C);
    check("R2 pair data type", lastIsData, 1);
  endtask

  task automatic testPairRead();
    rdData = 8'h96; rdOrEnable = 0; waitN(4);
    check("R4 pair read oe", dataOe, 1);
    check("R4 pair read data", dataOut, 8'h96);
    rdOrEnable = 1; waitN(4);
    check("R4 pair read release", dataOe, 0);
  endtask

  task automatic testEnWrites();
    int c;
    busStyle = 1; parallelMode = 1; selectChip(1); waitN(4);
    c = strobeCount;
    enWrite(8'h81, 0);
    check("R5 enable cmd count", strobeCount, c + 1);
    check("R5 enable cmd byte", lastByte, 8'h81);
    check("R2 enable cmd type", lastIsData, 0);
    enWrite(8'h7E, 1);
    check("R5 enable data byte", lastByte, 8'h7E);
    check("R2 enable data type", lastIsData, 1);
    // enable falling with direction=read: no write
    c = strobeCount;
    wrOrDir = 1; rdOrEnable = 1; waitN(4); rdOrEnable = 0; waitN(6);
    check("R5 enable fall during read ignored", strobeCount, c);
  endtask

  task automatic testEnRead();
    rdData = 8'h5B; wrOrDir = 1; rdOrEnable = 1; waitN(4);
    check("R6 enable read oe", dataOe, 1);
    check("R6 enable read data", dataOut, 8'h5B);
    rdOrEnable = 0; waitN(4);
    check("R6 enable read release", dataOe, 0);
  endtask

  task automatic testUnselected();
    int c;
    busStyle = 0; parallelMode = 1; rdOrEnable = 1;
    selLowN = 1; selHigh = 1; waitN(4);
    c = strobeCount;
    pairWrite(8'h11, 1);
    check("R1 low-select inactive no write", strobeCount, c);
    rdOrEnable = 0; waitN(4);
    check("R1 low-select inactive no oe", dataOe, 0);
    rdOrEnable = 1;
    selLowN = 0; selHigh = 0; waitN(4);
    pairWrite(8'h22, 0);
    check("R1 high-select inactive no write", strobeCount, c);
    rdOrEnable = 0; waitN(4);
    check("R1 high-select inactive no oe", dataOe, 0);
    rdOrEnable = 1; waitN(2);
  endtask

  task automatic testSerial();
    int c;
    parallelMode = 0; busIn = 0; selectChip(1); waitN(4);
    c = strobeCount;
    serialBits(8'hC3, 8, 0);
    check("R7 serial cmd count", strobeCount, c + 1);
    check("R7 serial cmd byte", lastByte, 8'hC3);
    check("R2 serial cmd type", lastIsData, 0);
    serialBits(8'h4D, 8, 1);
    check("R7 serial data byte", lastByte, 8'h4D);
    check("R2 serial data type", lastIsData, 1);
  endtask

  task automatic testSerialNoRead();
    int c;
    c = strobeCount;
    busStyle = 0; rdOrEnable = 0; waitN(4);
    check("R8 serial no oe with read strobe", dataOe, 0);
    wrOrDir = 0; waitN(4); wrOrDir = 1; waitN(6);
    busStyle = 1; rdOrEnable = 1; wrOrDir = 1; waitN(4);
    check("R8 serial no oe with enable read", dataOe, 0);
    wrOrDir = 0; rdOrEnable = 0; waitN(6); wrOrDir = 1;
    busStyle = 0; rdOrEnable = 1; waitN(4);
    check("R8 parallel strobes ignored in serial", strobeCount, c);
  endtask

  task automatic testAbort();
    int c;
    c = strobeCount;
    serialBits(8'hE0, 3, 1);
    selectChip(0); waitN(4); selectChip(1); waitN(4);
    serialBits(8'h5A, 8, 1);
    check("R9 abort one strobe", strobeCount, c + 1);
    check("R9 abort clean byte", lastByte, 8'h5A);
  endtask

  task automatic testResetMid();
    int c;
    serialBits(8'hE0, 3, 0);
    rstN = 0; waitN(3);
    check("R10 strobe low in reset", wrStrobe, 0);
    rstN = 1; waitN(4);
    c = strobeCount;
    serialBits(8'h3C, 8, 0);
    check("R10 reset cleared count", strobeCount, c + 1);
    check("R10 reset cleared byte", lastByte, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitN(4);
    testReset();
    rstN = 1; waitN(4);
    testPairWrites();
    testPairRead();
    testEnWrites();
    testEnRead();
    testUnselected();
    testSerial();
    testSerialNoRead();
    testAbort();
    testResetMid();
    finishRun();
  end

endmodule